// File: doc/BRIEF.md
# Processor and Peripheral Clock Mode Selector

This block turns one fast main clock and a slow-tick input into two clock-enable strobes. One strobe is for the processor and one is for the peripherals. Both are single-cycle pulses in the main clock domain, so downstream logic keeps running on the main clock and advances only when its strobe is high. A 3-bit mode field picks the rate. Five fast modes divide the main clock by 1, 2, 4, 6 or 8. In one fast mode only the processor is slowed and the peripherals keep full rate. Two slow modes take their strobes from the slow tick, optionally divided by a power of two.

The block also has four small outputs. It drives an enable for the external main oscillator, which is turned off in one slow mode. It produces a clock-output pin that can carry the peripheral strobe, a half-rate square wave of it, or a constant low. It forwards the raw slow tick to the watchdog and real-time consumers. It blocks the periodic-interrupt tick while the slow clock drives the strobes.

Mode and prescale requests are latched only at a processor-strobe boundary. At that point every divider counter restarts from zero, so no strobe interval is ever shortened by a reconfiguration.

Top module: `clk_mode_sel`

## Requirements
- R1: Mode code 3'b010 asserts both `cpu_en_o` and `per_en_o` in every main-clock cycle.
- R2: Mode codes 3'b011, 3'b110 and 3'b111 pulse both strobes once every 2, 4 and 6 main-clock cycles respectively, with both strobes in the same cycle.
- R3: During and after reset the mode is 3'b000. In that mode both strobes pulse once every 8 cycles, the first one on the 8th rising edge after reset release. In reset both strobes and `clkout_o` are low and `osc_en_o` is high.
- R4: Mode code 3'b001 pulses `cpu_en_o` once every 8 cycles while `per_en_o` stays high in every cycle. Whenever `cpu_en_o` is high, `per_en_o` is high too.
- R5: Mode code 3'b100 pulses both strobes once per 2^k slow ticks, where k is `slow_pre_i` clamped to 4 (codes 0..4 give 1, 2, 4, 8, 16; codes 5..7 give 16). A strobe only follows a cycle in which `slow_tick_i` was high.
- R6: Mode code 3'b101 behaves as 3'b100 and drives `osc_en_o` low. In every other mode `osc_en_o` is high.
- R7: `wdt_tick_o` equals `slow_tick_i` in every mode, undivided.
- R8: `pit_tick_o` equals `pit_tick_i` in the fast modes and is held low in modes 3'b100 and 3'b101.
- R9: `clkout_sel_i` 2'b00 or 2'b01 holds `clkout_o` low. With 2'b10, `clkout_o` equals `per_en_o` in the same cycle. With 2'b11, `clkout_o` toggles once per peripheral strobe.
- R10: `mode_i` and `slow_pre_i` are taken only in the cycle that produces a processor strobe. Changes between strobes, including ones reverted before the next strobe, have no effect. The interval that ends at the switch keeps the old length, and the first interval after it is a full interval of the new mode. In a slow mode with no slow ticks, a request for a fast mode waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Requested clock mode code |
| slow_pre_i | input | PRE_W | Slow-tick prescale exponent |
| clkout_sel_i | input | 2 | Clock-output pin source select |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period, synchronous to `clk` |
| pit_tick_i | input | 1 | Periodic-interrupt tick from its generator |
| cpu_en_o | output | 1 | Processor clock-enable strobe |
| per_en_o | output | 1 | Peripheral clock-enable strobe |
| osc_en_o | output | 1 | External main oscillator enable (low = stop) |
| clkout_o | output | 1 | Clock-output pin value |
| wdt_tick_o | output | 1 | Undivided slow tick for watchdog and real-time consumers |
| pit_tick_o | output | 1 | Gated periodic-interrupt tick |

## Verification
The bench uses the default `PRE_W` = 3 and `PRE_MAX` = 4. With these values a prescale code above the largest exponent (code 7) can be driven, so the clamp to divide-by-16 is exercised. With a slow tick every third cycle, a 144-cycle window holds a whole number of periods for every fast divider and every slow prescale. Strobe counts over that window are therefore exact, whatever the phase. The small fast counter keeps the boundary-only switching visible within single intervals of 8 cycles, including a request that is withdrawn before the next boundary.

// File: rtl/clkm_pkg.sv
`timescale 1ns/1ps
package clkm_pkg;

    localparam int MODE_W = 3;
    localparam int DIV_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_DIV8         = 3'b000,
        MODE_CPU8         = 3'b001,
        MODE_FULL         = 3'b010,
        MODE_DIV2         = 3'b011,
        MODE_SLOW         = 3'b100,
        MODE_SLOW_OSC_OFF = 3'b101,
        MODE_DIV4         = 3'b110,
        MODE_DIV6         = 3'b111
    } mode_e;

    typedef enum logic [1:0] {
        PIN_LOW     = 2'b00,
        PIN_LOW_ALT = 2'b01,
        PIN_PER     = 2'b10,
        PIN_HALF    = 2'b11
    } pin_sel_e;

    function automatic logic is_slow(mode_e m);
        return (m == MODE_SLOW) || (m == MODE_SLOW_OSC_OFF);
    endfunction

    // terminal count of the main-clock divider for each fast mode
    function automatic logic [DIV_W-1:0] div_last(mode_e m);
        case (m)
            MODE_FULL: return DIV_W'(0);
            MODE_DIV2: return DIV_W'(1);
            MODE_DIV4: return DIV_W'(3);
            MODE_DIV6: return DIV_W'(5);
            MODE_DIV8: return DIV_W'(7);
            MODE_CPU8: return DIV_W'(7);
            default:   return DIV_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/clkm_fast_div.sv
`timescale 1ns/1ps
module clkm_fast_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [DIV_W-1:0] last_i,
    output logic             wrap_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } fd_st_t;

    fd_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = !hold_i && (st_q.cnt == last_i);
        if (hold_i || wrap_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) st_q.cnt <= last_i) else $error("fast counter past terminal"); // R2

endmodule

// File: rtl/clkm_slow_div.sv
`timescale 1ns/1ps
module clkm_slow_div #(
    parameter int PRE_W   = 3,
    parameter int PRE_MAX = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             tick_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             wrap_o
);
    localparam int PC_W = (PRE_MAX < 1) ? 1 : PRE_MAX;

    typedef struct packed {
        logic [PC_W-1:0] pcnt;
    } sd_st_t;

    sd_st_t          st_d, st_q;
    logic [PRE_W-1:0] exp_c;
    logic [PC_W-1:0]  ones_c;
    logic [PC_W-1:0]  mask_c;

    always_comb begin
        st_d   = st_q;
        exp_c  = (pre_i > PRE_W'(PRE_MAX)) ? PRE_W'(PRE_MAX) : pre_i;
        ones_c = '1;
        mask_c = ~(ones_c << exp_c);
        wrap_o = !hold_i && tick_i && (st_q.pcnt == mask_c);
        if (hold_i || wrap_o) begin
            st_d.pcnt = '0;
        end else if (tick_i) begin
            st_d.pcnt = st_q.pcnt + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) st_q.pcnt <= mask_c) else $error("prescale counter past mask"); // R5
    AST_WRAP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) !tick_i |=> $stable(st_q.pcnt)) else $error("prescaler moved without tick"); // R5

endmodule

// File: rtl/clkm_pin_drv.sv
`timescale 1ns/1ps
module clkm_pin_drv
    import clkm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  mode_e  act_q_i,
    input  mode_e  act_d_i,
    input  logic   per_d_i,
    input  logic [1:0] sel_i,
    input  logic   pit_tick_i,
    output logic   clkout_o,
    output logic   osc_en_o,
    output logic   pit_tick_o
);
    typedef struct packed {
        logic clkout;
        logic osc_en;
    } pd_st_t;

    pd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (pin_sel_e'(sel_i))
            PIN_PER:  st_d.clkout = per_d_i;
            PIN_HALF: st_d.clkout = per_d_i ? ~st_q.clkout : st_q.clkout;
            default:  st_d.clkout = 1'b0;
        endcase
        st_d.osc_en = (act_d_i != MODE_SLOW_OSC_OFF);
        pit_tick_o  = pit_tick_i && !is_slow(act_q_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{clkout: 1'b0, osc_en: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign clkout_o = st_q.clkout;
    assign osc_en_o = st_q.osc_en;

    AST_PIN_LOW_SEL: assert property (@(posedge clk) disable iff (!rst_n) !sel_i[1] |=> !clkout_o) else $error("clock pin not low"); // R9

endmodule

// File: rtl/clk_mode_sel.sv
`timescale 1ns/1ps
module clk_mode_sel
    import clkm_pkg::*;
#(
    parameter int PRE_W   = 3,
    parameter int PRE_MAX = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [PRE_W-1:0]     slow_pre_i,
    input  logic [1:0]           clkout_sel_i,
    input  logic                 slow_tick_i,
    input  logic                 pit_tick_i,
    output logic                 cpu_en_o,
    output logic                 per_en_o,
    output logic                 osc_en_o,
    output logic                 clkout_o,
    output logic                 wdt_tick_o,
    output logic                 pit_tick_o
);
    typedef struct packed {
        mode_e            act;
        logic [PRE_W-1:0] pre;
        logic             cpu_en;
        logic             per_en;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             slow_now;
    logic [DIV_W-1:0] fast_last;
    logic             fast_wrap;
    logic             slow_wrap;
    logic             boundary;

    assign slow_now  = is_slow(st_q.act);
    assign fast_last = div_last(st_q.act);

    clkm_fast_div #(.DIV_W(DIV_W)) u_fast (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (slow_now),
        .last_i (fast_last),
        .wrap_o (fast_wrap)
    );

    clkm_slow_div #(.PRE_W(PRE_W), .PRE_MAX(PRE_MAX)) u_slow (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (!slow_now),
        .tick_i (slow_tick_i),
        .pre_i  (st_q.pre),
        .wrap_o (slow_wrap)
    );

    always_comb begin
        st_d        = st_q;
        boundary    = slow_now ? slow_wrap : fast_wrap;
        st_d.cpu_en = boundary;
        st_d.per_en = (st_q.act == MODE_CPU8) || boundary;
        if (boundary) begin
            st_d.act = mode_e'(mode_i);
            st_d.pre = slow_pre_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{act: MODE_DIV8, pre: '0, cpu_en: 1'b0, per_en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    clkm_pin_drv u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_q_i    (st_q.act),
        .act_d_i    (st_d.act),
        .per_d_i    (st_d.per_en),
        .sel_i      (clkout_sel_i),
        .pit_tick_i (pit_tick_i),
        .clkout_o   (clkout_o),
        .osc_en_o   (osc_en_o),
        .pit_tick_o (pit_tick_o)
    );

    assign cpu_en_o   = st_q.cpu_en;
    assign per_en_o   = st_q.per_en;
    assign wdt_tick_o = slow_tick_i;

    AST_CPU_IMPLIES_PER: assert property (@(posedge clk) disable iff (!rst_n) cpu_en_o |-> per_en_o) else $error("cpu strobe without peripheral strobe"); // R4
    AST_CPU8_PER_FULL: assert property (@(posedge clk) disable iff (!rst_n) (st_q.act == MODE_CPU8) |=> per_en_o) else $error("peripheral not full rate"); // R4
    AST_SLOW_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) (slow_now && !slow_tick_i) |=> !cpu_en_o) else $error("slow strobe without tick"); // R5
    AST_OSC_OFF_QUIET_PIT: assert property (@(posedge clk) disable iff (!rst_n) !osc_en_o |-> !pit_tick_o) else $error("interrupt tick while oscillator off"); // R8
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !boundary |=> $stable(st_q.act) && $stable(st_q.pre)) else $error("mode moved off boundary"); // R10
    AST_PIN_FOLLOWS_PER: assert property (@(posedge clk) disable iff (!rst_n) (clkout_sel_i == 2'b10) |=> (clkout_o == per_en_o)) else $error("clock pin not following strobe"); // R9

endmodule

// File: tb/clk_mode_sel_test.sv
`timescale 1ns/1ps
module clk_mode_sel_test;

    localparam int PRE_W = 3;
    localparam int WIN   = 144;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode_i = 3'b000;
    logic [PRE_W-1:0] slow_pre_i = '0;
    logic [1:0]       clkout_sel_i = 2'b10;
    logic             slow_tick_i = 1'b0;
    logic             pit_tick_i = 1'b1;
    logic             cpu_en_o, per_en_o, osc_en_o, clkout_o, wdt_tick_o, pit_tick_o;

    int  total = 0;
    int  bad = 0;
    bit  tick_run = 1'b1;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    clk_mode_sel #(.PRE_W(PRE_W), .PRE_MAX(4)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .slow_pre_i(slow_pre_i),
        .clkout_sel_i(clkout_sel_i), .slow_tick_i(slow_tick_i), .pit_tick_i(pit_tick_i),
        .cpu_en_o(cpu_en_o), .per_en_o(per_en_o), .osc_en_o(osc_en_o),
        .clkout_o(clkout_o), .wdt_tick_o(wdt_tick_o), .pit_tick_o(pit_tick_o)
    );

    // slow tick: one cycle in three, changed just after the rising edge
    initial begin
        int tc = 0;
        forever begin
            @(posedge clk);
            #1;
            tc = (tc == 2) ? 0 : tc + 1;
            slow_tick_i = tick_run && (tc == 2);
        end
    end

    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] pre;
        logic [7:0] cpu;
        logic [7:0] per;
        logic       osc;
        logic       pit;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{3'b010, 3'd0, 8'd144, 8'd144, 1'b1, 1'b1},
        '{3'b011, 3'd0, 8'd72,  8'd72,  1'b1, 1'b1},
        '{3'b110, 3'd0, 8'd36,  8'd36,  1'b1, 1'b1},
        '{3'b111, 3'd0, 8'd24,  8'd24,  1'b1, 1'b1},
        '{3'b000, 3'd0, 8'd18,  8'd18,  1'b1, 1'b1},
        '{3'b001, 3'd0, 8'd18,  8'd144, 1'b1, 1'b1},
        '{3'b100, 3'd0, 8'd48,  8'd48,  1'b1, 1'b0},
        '{3'b100, 3'd1, 8'd24,  8'd24,  1'b1, 1'b0},
        '{3'b100, 3'd2, 8'd12,  8'd12,  1'b1, 1'b0},
        '{3'b100, 3'd3, 8'd6,   8'd6,   1'b1, 1'b0},
        '{3'b101, 3'd4, 8'd3,   8'd3,   1'b0, 1'b0},
        '{3'b100, 3'd7, 8'd3,   8'd3,   1'b1, 1'b0}
    };

    function automatic string req_for(logic [2:0] m);
        case (m)
            3'b010:                 return "R1";
            3'b011, 3'b110, 3'b111: return "R2";
            3'b000:                 return "R3";
            3'b001:                 return "R4";
            3'b100:                 return "R5";
            default:                return "R6";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic measure(output int nc, output int np, output int nw,
                           output int npit, output int nhi, output int ntg);
        logic prev;
        nc = 0; np = 0; nw = 0; npit = 0; nhi = 0; ntg = 0;
        prev = clkout_o;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            nc   += int'(cpu_en_o);
            np   += int'(per_en_o);
            nw   += int'(wdt_tick_o);
            npit += int'(pit_tick_o);
            nhi  += int'(clkout_o);
            ntg  += int'(clkout_o != prev);
            prev = clkout_o;
        end
    endtask

    task automatic gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_en_o && g < 200);
    endtask

    task automatic sync_pulse();
        int g;
        gap(g);
    endtask

    initial begin
        #(4 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        int nc, np, nw, npit, nhi, ntg, g;

        // reset state, R3
        repeat (4) @(negedge clk);
        check("R3", "reset cpu_en", int'(cpu_en_o), 0);
        check("R3", "reset per_en", int'(per_en_o), 0);
        check("R3", "reset osc_en", int'(osc_en_o), 1);
        check("R3", "reset clkout", int'(clkout_o), 0);
        rst_n = 1'b1;
        gap(g);
        check("R3", "first strobe after reset", g, 8);
        check("R3", "first peripheral strobe with cpu", int'(per_en_o), 1);

        // table walk: R1..R9 at steady state
        foreach (VEC[k]) begin
            @(negedge clk);
            mode_i     = VEC[k].mode;
            slow_pre_i = VEC[k].pre;
            repeat (60) @(negedge clk);
            measure(nc, np, nw, npit, nhi, ntg);
            check(req_for(VEC[k].mode), "cpu strobes", nc, int'(VEC[k].cpu));
            check(req_for(VEC[k].mode), "per strobes", np, int'(VEC[k].per));
            check("R6", "osc_en", int'(osc_en_o), int'(VEC[k].osc));
            check("R7", "wdt ticks", nw, 48);
            check("R8", "pit ticks", npit, VEC[k].pit ? WIN : 0);
            check("R9", "clkout follows per", nhi, int'(VEC[k].per));
        end

        // R10: request between boundaries waits for the boundary
        @(negedge clk);
        mode_i = 3'b000; slow_pre_i = '0;
        repeat (60) @(negedge clk);
        sync_pulse();
        mode_i = 3'b011;
        gap(g);
        check("R10", "old interval kept", g, 8);
        gap(g);
        check("R10", "first new interval", g, 2);

        // R10: withdrawn request has no effect
        mode_i = 3'b000;
        repeat (20) @(negedge clk);
        sync_pulse();
        g = 0;
        np = 0;
        mode_i = 3'b010;
        repeat (3) begin
            @(negedge clk);
            g++;
            np += int'(per_en_o);
        end
        mode_i = 3'b000;
        do begin
            @(negedge clk);
            g++;
        end while (!cpu_en_o && g < 200);
        check("R10", "withdrawn request gap", g, 8);
        check("R10", "no strobe from withdrawn request", np, 0);

        // R9: half-rate pin and low selections
        mode_i = 3'b010;
        clkout_sel_i = 2'b11;
        repeat (20) @(negedge clk);
        measure(nc, np, nw, npit, nhi, ntg);
        check("R9", "half-rate toggles full mode", ntg, WIN);
        mode_i = 3'b011;
        repeat (20) @(negedge clk);
        measure(nc, np, nw, npit, nhi, ntg);
        check("R9", "half-rate toggles div2", ntg, 72);
        clkout_sel_i = 2'b00;
        repeat (4) @(negedge clk);
        measure(nc, np, nw, npit, nhi, ntg);
        check("R9", "sel 00 pin highs", nhi, 0);
        clkout_sel_i = 2'b01;
        repeat (4) @(negedge clk);
        measure(nc, np, nw, npit, nhi, ntg);
        check("R9", "sel 01 pin highs", nhi, 0);
        clkout_sel_i = 2'b10;

        // R10: leaving a slow mode waits for a slow tick
        mode_i = 3'b100; slow_pre_i = '0;
        repeat (60) @(negedge clk);
        tick_run = 1'b0;
        repeat (4) @(negedge clk);
        mode_i = 3'b010;
        repeat (40) @(negedge clk);
        measure(nc, np, nw, npit, nhi, ntg);
        check("R10", "stuck without slow tick cpu", nc, 0);
        check("R5", "no strobe without slow tick", np, 0);
        tick_run = 1'b1;
        repeat (20) @(negedge clk);
        measure(nc, np, nw, npit, nhi, ntg);
        check("R10", "fast mode after slow tick", nc, WIN);

        finish_run();
    end

endmodule